// File: doc/BRIEF.md
# Link Wake-Up Signal Generator

This block produces the wake-up indication that asks a powered-down or idle link-layer controller to come back up. The link is taken as awake only when its power-status input (already qualified by the power-status filter elsewhere) is active and the link-control register bit is set. While the link is not awake, the block arms on either of two causes: a strobe for a received link-on packet addressed to this node, or a qualifying interrupt condition. A qualifying condition is the port-event flag, or any resume-related flag (configuration timeout, cable power, state timeout) while the resume interrupt enable is set.

When armed, the output is a square wave clocked by the system clock, beginning high in the first cycle after arming. It remains armed until the link becomes awake. A bus reset disarms a wake caused only by a packet and leaves it armed when an interrupt condition is present. An interrupt condition that appears while the link is awake is not lost: the output arms as soon as the link drops.

The output is driven low when not armed. During hardware reset it is released; the enable for the output pad is brought out as its own signal, so the pad tri-state sits outside this block.

Top module: `lnk_wake_gen`

## Requirements
- R1: While armed, `wake_o` is a square wave of period PERIOD_CYC cycles (default 8): high for PERIOD_CYC/2 cycles, then low for PERIOD_CYC/2 cycles, starting high in the first cycle after arming.
- R2: The link counts as awake only when `lps_ok_i` = 1 and `lctl_i` = 1; with either at 0 it counts as asleep.
- R3: While the link is asleep, the block arms in the cycle after any of: `linkon_pkt_i` = 1, `port_ev_i` = 1, or any bit of `res_ev_i` = 1 together with `res_int_en_i` = 1. Bits of `res_ev_i` with `res_int_en_i` = 0 do not arm it.
- R4: Once armed, the block stays armed while the link is asleep, even after all interrupt flags return to 0, until the link is awake; it is disarmed and `wake_o` is 0 from the cycle after the link is seen awake.
- R5: A `bus_reset_i` pulse disarms a wake caused only by a link-on packet (in the cycle after the pulse); if a qualifying interrupt condition holds in the pulse cycle, the block stays armed. A packet strobe in the same cycle as a bus reset is dropped.
- R6: A qualifying interrupt condition held while the link is awake arms the block in the cycle after the link is seen asleep; a link-on packet received while the link is awake is dropped.
- R7: `wake_o` is 0 whenever the block is not armed; `wake_oe_o` is 0 while `rst_n` is low and 1 otherwise, and a hardware reset disarms the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| lps_ok_i | input | 1 | Qualified link power status, 1 = active |
| lctl_i | input | 1 | Link-control register bit |
| linkon_pkt_i | input | 1 | One-cycle strobe: link-on packet for this node received |
| port_ev_i | input | 1 | Port-event interrupt flag |
| res_ev_i | input | NUM_RES_EV | Resume-related interrupt flags (configuration timeout, cable power, state timeout) |
| res_int_en_i | input | 1 | Resume interrupt enable |
| bus_reset_i | input | 1 | One-cycle strobe: bus reset occurred |
| wake_o | output | 1 | Wake-up square wave, low when not armed |
| wake_oe_o | output | 1 | Output-enable for the wake pad, 0 during hardware reset |

## Verification
The bench builds the block with its defaults, PERIOD_CYC = 8 and NUM_RES_EV = 3. Eight cycles per period keep whole periods short enough to check every half-period boundary many times over a random run, and three separate resume flags allow each one to be tested alone against the enable. Random link activity and overlapping strobes then bring the same-cycle corners of bus reset, packet arrival and link wake-up within reach.

// File: rtl/lnk_wake_pkg.sv
package lnk_wake_pkg;

  typedef struct packed {
    logic pkt;   // armed by a link-on packet
    logic irq;   // armed by an interrupt condition
  } wake_cause_t;

  function automatic logic link_is_awake(input logic pwr_ok, input logic ctl_bit);
    return pwr_ok & ctl_bit;
  endfunction

  function automatic logic irq_qualifies(input logic port_flag, input logic any_res,
                                         input logic res_en);
    return port_flag | (any_res & res_en);
  endfunction

  // Next arming state from the current one and this cycle's events.
  function automatic wake_cause_t cause_next(input wake_cause_t cur, input logic awake,
                                             input logic brst, input logic pkt_stb,
                                             input logic irq_cond);
    wake_cause_t n;
    if (awake) begin
      n.pkt = 1'b0;
      n.irq = 1'b0;
    end else if (brst) begin
      n.pkt = 1'b0;
      n.irq = irq_cond;
    end else begin
      n.pkt = cur.pkt | pkt_stb;
      n.irq = cur.irq | irq_cond;
    end
    return n;
  endfunction

  // Square-wave level for a phase counter value.
  function automatic logic wave_level(input int unsigned phase, input int unsigned half);
    return phase < half;
  endfunction

endpackage

// File: rtl/lnk_wake_cause.sv
module lnk_wake_cause
  import lnk_wake_pkg::*;
#(
  parameter int NUM_RES_EV = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwr_ok,
  input  logic                  ctl_bit,
  input  logic                  pkt_stb,
  input  logic                  port_flag,
  input  logic [NUM_RES_EV-1:0] res_flags,
  input  logic                  res_en,
  input  logic                  brst,
  output logic                  awake,
  output logic                  irq_cond,
  output wake_cause_t           cause_q
);

  logic any_res;

  assign any_res  = |res_flags;
  assign awake    = link_is_awake(pwr_ok, ctl_bit);
  assign irq_cond = irq_qualifies(port_flag, any_res, res_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else begin
      cause_q <= cause_next(cause_q, awake, brst, pkt_stb, irq_cond);
    end
  end

endmodule

// File: rtl/lnk_wake_sqw.sv
module lnk_wake_sqw
  import lnk_wake_pkg::*;
#(
  parameter int PERIOD_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic level
);

  localparam int HALF  = PERIOD_CYC / 2;
  localparam int CNT_W = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

  logic [CNT_W-1:0] phase_q;

  // Held at zero while idle, so each arming starts a fresh high half.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!run) begin
      phase_q <= '0;
    end else if (phase_q == LAST) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign level = run & wave_level(int'(unsigned'(phase_q)), HALF);

endmodule

// File: rtl/lnk_wake_gen.sv
module lnk_wake_gen
  import lnk_wake_pkg::*;
#(
  parameter int PERIOD_CYC = 8,
  parameter int NUM_RES_EV = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lps_ok_i,
  input  logic                  lctl_i,
  input  logic                  linkon_pkt_i,
  input  logic                  port_ev_i,
  input  logic [NUM_RES_EV-1:0] res_ev_i,
  input  logic                  res_int_en_i,
  input  logic                  bus_reset_i,
  output logic                  wake_o,
  output logic                  wake_oe_o
);

  // Named internal events, observed by the bound checker.
  logic        link_awake;
  logic        irq_cond;
  wake_cause_t cause_q;
  logic        pkt_pend;
  logic        irq_pend;
  logic        wake_on;

  lnk_wake_cause #(
    .NUM_RES_EV(NUM_RES_EV)
  ) cause_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_ok   (lps_ok_i),
    .ctl_bit  (lctl_i),
    .pkt_stb  (linkon_pkt_i),
    .port_flag(port_ev_i),
    .res_flags(res_ev_i),
    .res_en   (res_int_en_i),
    .brst     (bus_reset_i),
    .awake    (link_awake),
    .irq_cond (irq_cond),
    .cause_q  (cause_q)
  );

  assign pkt_pend = cause_q.pkt;
  assign irq_pend = cause_q.irq;
  assign wake_on  = pkt_pend | irq_pend;

  lnk_wake_sqw #(
    .PERIOD_CYC(PERIOD_CYC)
  ) sqw_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (wake_on),
    .level(wake_o)
  );

  assign wake_oe_o = rst_n;

endmodule

// File: rtl/lnk_wake_chk.sv
module lnk_wake_chk #(
  parameter int PERIOD_CYC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic link_awake,
  input logic irq_cond,
  input logic linkon_pkt_i,
  input logic bus_reset_i,
  input logic irq_pend,
  input logic wake_on,
  input logic wake_o,
  input logic wake_oe_o
);

  localparam int HALF = PERIOD_CYC / 2;

  // Length of the current constant-level run of wake_o while armed.
  logic [15:0] run_q;
  logic        prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= wake_o;
      if (!wake_on) run_q <= '0;
      else if (run_q == 16'd0 || wake_o != prev_q) run_q <= 16'd1;
      else if (run_q != 16'hFFFF) run_q <= run_q + 16'd1;
    end
  end

  AST_FIRST_HALF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_on) |-> wake_o);                                          // R1

  AST_HALF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    wake_on |-> (run_q <= 16'(HALF)));                                   // R1

  AST_PKT_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_awake && linkon_pkt_i && !bus_reset_i) |=> wake_on);          // R3

  AST_IRQ_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_awake && irq_cond) |=> wake_on);                              // R3

  AST_AWAKE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    link_awake |=> !wake_on);                                            // R4

  AST_HOLD_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_on && !link_awake && !bus_reset_i) |=> wake_on);               // R4

  AST_BRST_PKT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset_i && !irq_cond) |=> !wake_on);                            // R5

  AST_BRST_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset_i && irq_cond && !link_awake) |=> irq_pend);              // R5

  AST_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_on |-> !wake_o);                                               // R7

  always_comb begin
    if (!rst_n) begin
      AST_RELEASE_IN_RESET: assert (!wake_oe_o);                         // R7
    end
  end

endmodule

bind lnk_wake_gen lnk_wake_chk #(
  .PERIOD_CYC(PERIOD_CYC)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .link_awake  (link_awake),
  .irq_cond    (irq_cond),
  .linkon_pkt_i(linkon_pkt_i),
  .bus_reset_i (bus_reset_i),
  .irq_pend    (irq_pend),
  .wake_on     (wake_on),
  .wake_o      (wake_o),
  .wake_oe_o   (wake_oe_o)
);

// File: tb/lnk_wake_gen_tb_top.sv
`timescale 1ns/1ps
module lnk_wake_gen_tb_top;

  localparam int P  = 8;
  localparam int NR = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lps = 1'b1, lctl = 1'b1, pkt = 1'b0, port = 1'b0, ren = 1'b0, brst = 1'b0;
  logic [NR-1:0] res = '0;
  logic          wake, oe;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  lnk_wake_gen #(.PERIOD_CYC(P), .NUM_RES_EV(NR)) dut_i (
    .clk(clk), .rst_n(rst_n), .lps_ok_i(lps), .lctl_i(lctl), .linkon_pkt_i(pkt),
    .port_ev_i(port), .res_ev_i(res), .res_int_en_i(ren), .bus_reset_i(brst),
    .wake_o(wake), .wake_oe_o(oe)
  );

  // ---- reference model, written from the requirements ----
  function automatic bit m_awake(bit p, bit c);  // R2
    return p && c;
  endfunction
  function automatic bit m_qual(bit pe, logic [NR-1:0] r, bit en);  // R3
    return pe || ((r != '0) && en);
  endfunction

  bit m_by_pkt = 0, m_by_int = 0;
  int m_age = 0;  // cycles since arming

  always @(posedge clk or negedge rst_n) begin
    bit np, ni, aw, q;
    if (!rst_n) begin
      m_by_pkt <= 0; m_by_int <= 0; m_age <= 0;
    end else begin
      aw = m_awake(lps, lctl);
      q  = m_qual(port, res, ren);
      np = m_by_pkt; ni = m_by_int;
      if (aw) begin np = 0; ni = 0; end
      else if (brst) begin np = 0; ni = q; end
      else begin if (pkt) np = 1; if (q) ni = 1; end
      if ((np || ni) && (m_by_pkt || m_by_int)) m_age <= m_age + 1;
      else m_age <= 0;
      m_by_pkt <= np; m_by_int <= ni;
    end
  end

  function automatic bit m_wave();
    return (m_by_pkt || m_by_int) && ((m_age % P) < (P / 2));
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Advance one cycle and compare outputs at the following falling edge.
  task automatic cyc(input string tag);
    @(negedge clk);
    check(wake, m_wave(), tag);
    check(oe, 1'b1, {tag, " oe"});
  endtask

  task automatic idle();
    pkt = 0; port = 0; res = '0; ren = 0; brst = 0;
  endtask

  task automatic wake_link();  // bring link awake to disarm
    idle(); lps = 1; lctl = 1;
    cyc("R4 disarm");
    check(wake, 1'b0, "R4 off after awake");
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    #1;
    check(oe, 1'b0, "R7 oe in reset");
    check(wake, 1'b0, "R7 wake in reset");
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc("R7 after reset");

    // R2: either input low means asleep
    lctl = 0; pkt = 1; cyc("R2 lctl=0 arms"); pkt = 0;
    check(wake, 1'b1, "R2 wake high with lctl=0");
    lctl = 1; cyc("R2 both high awake");
    lps = 0; pkt = 1; cyc("R2 lps=0 arms"); pkt = 0;
    check(wake, 1'b1, "R2 wake high with lps=0");
    wake_link();

    // R1: two whole periods of the wave
    lctl = 0; pkt = 1; cyc("R1 arm"); pkt = 0;
    for (int i = 1; i < 2 * P; i++) begin
      cyc("R1 wave");
      check(wake, ((i % P) < (P / 2)), "R1 literal pattern");
    end
    wake_link();

    // R3: resume flags gated by enable, each alone
    lctl = 0;
    for (int b = 0; b < NR; b++) begin
      res = '0; res[b] = 1'b1; ren = 0;
      cyc("R3 res flag without enable");
      check(wake, 1'b0, "R3 no arm when disabled");
    end
    for (int b = 0; b < NR; b++) begin
      lctl = 0; res = '0; res[b] = 1'b1; ren = 1;
      cyc("R3 res flag with enable");
      check(wake, 1'b1, "R3 arms with enable");
      wake_link();
    end
    lctl = 0; port = 1; cyc("R3 port event arms"); port = 0;
    check(wake, 1'b1, "R3 port event");

    // R4: stays armed after flag clears
    repeat (12) cyc("R4 hold after flag clears");
    wake_link();

    // R5: bus reset against packet-only and interrupt causes
    lctl = 0; pkt = 1; cyc("R5 pkt arm"); pkt = 0;
    brst = 1; cyc("R5 brst pkt only"); brst = 0;
    check(wake, 1'b0, "R5 packet wake cleared");
    port = 1; cyc("R5 irq arm");
    brst = 1; cyc("R5 brst with irq"); brst = 0; port = 0;
    check(wake, 1'b1, "R5 irq wake kept");
    wake_link();
    lctl = 0; brst = 1; pkt = 1; cyc("R5 same-cycle pkt dropped");
    check(wake, 1'b0, "R5 pkt with brst dropped"); idle();

    // R6: pending irq while awake, packet while awake
    lctl = 1; pkt = 1; cyc("R6 pkt while awake"); pkt = 0;
    lctl = 0; cyc("R6 dropped pkt");
    check(wake, 1'b0, "R6 pkt while awake dropped");
    lctl = 1; res = 3'b010; ren = 1; repeat (3) cyc("R6 irq while awake");
    check(wake, 1'b0, "R6 no wake while awake");
    lctl = 0; cyc("R6 arm on sleep");
    check(wake, 1'b1, "R6 armed after link drops");
    wake_link();

    // R7: hardware reset disarms and releases
    lctl = 0; port = 1; cyc("R7 arm"); port = 0;
    @(negedge clk); rst_n = 0; #1;
    check(oe, 1'b0, "R7 oe low in reset");
    check(wake, 1'b0, "R7 wake low in reset");
    @(negedge clk); rst_n = 1;
    cyc("R7 after second reset");

    // Random mix: checks R1 R2 R3 R4 R5 R6 R7 together
    for (int k = 0; k < 4000; k++) begin
      lps  = ($urandom % 8) != 0;
      lctl = ($urandom % 4) == 0;
      pkt  = ($urandom % 16) == 0;
      port = ($urandom % 40) == 0;
      res  = NR'(($urandom % 12) == 0 ? ($urandom % 8) : 0);
      ren  = $urandom % 2;
      brst = ($urandom % 24) == 0;
      cyc("R1 R2 R3 R4 R5 R6 R7 random");
    end
    idle();
    cyc("R7 final");

    summary();
    $finish;
  end

endmodule